// File: doc/BRIEF.md
# Receive Descriptor Ring DMA Engine

This block moves incoming network frames from a byte stream into memory buffers that software describes with a linked chain of receive descriptors. Each descriptor is four 32-bit little-endian words in memory: a status-and-length word at offset 0, the buffer start address at offset 4, an unused word at offset 8 and the address of the next descriptor at offset 12. The engine reads the descriptor at its current pointer. When the owner field shows that the engine holds the descriptor, it packs the frame bytes (the trailing 4 CRC bytes included) into the buffer. It then writes a status word that hands the descriptor back to the CPU and follows the next-descriptor link.

Software controls the engine through a few level inputs: receive enable, accept-unicast enable, long-frame allow and receive-interrupt enable. It can also pulse a resume strobe. Each event drives single-cycle strobes on an interrupt-status-set vector, whose bit positions a neighbouring register file decodes. The current descriptor pointer is exported to that register file. When a descriptor is not available, the engine discards frames until it receives a resume pulse.

State machine:
- `ST_OFF`: the pointer follows `list_base` and stream bytes are discarded. Goes to `ST_RD_STAT` when both enables are set.
- `ST_RD_STAT`: reads the status word. Goes to `ST_RD_BUF` if the engine owns the descriptor, otherwise to `ST_STALL`.
- `ST_RD_BUF`: reads the buffer address, then goes to `ST_RD_NEXT`.
- `ST_RD_NEXT`: reads the link, then goes to `ST_RECV`.
- `ST_RECV`: takes bytes. On a full or final word it goes to `ST_WR_DATA`, unless the frame is being dropped. Goes back to `ST_OFF` when the enables drop between frames.
- `ST_WR_DATA`: writes the word. Goes to `ST_WR_STAT` at the end of the frame, otherwise back to `ST_RECV`.
- `ST_WR_STAT`: writes the status word, advances the pointer and goes to `ST_RD_STAT`.
- `ST_STALL`: discards bytes. Goes to `ST_RD_STAT` on `start_demand`, or to `ST_OFF` when disabled.

Top module: `rxdesc_dma`

## Requirements
- R1: After reset no memory request or status strobe is active, `s_ready` is 1 and `cur_desc` equals `list_base` while reception is disabled.
- R2: Unless both `rx_on` and `accept_unicast` are 1, stream bytes are consumed and discarded, with no memory access and no descriptor change.
- R3: The engine reads the status word at `cur_desc`. Only when bits 31:30 equal 2'b10 does it read the buffer address (offset 4) and the next-descriptor address (offset 12) and start receiving.
- R4: Frame byte i is stored at buffer start + i, in little-endian byte lanes. Byte enables leave the unused lanes of a partial final word untouched.
- R5: The written-back status word has bits 31:30 = 2'b00 and bit 20 = 1, and its bits 15:0 equal the number of bytes received, CRC included.
- R6: Status bit 16 of the written-back word equals `rx_irq_en`.
- R7: A stored frame produces a one-cycle strobe on `irq_set` bits 0, 4 and 9 together.
- R8: After a frame is stored, `cur_desc` takes the next-descriptor address read from the completed descriptor.
- R9: A frame longer than `MAX_FRAME` bytes, received with `long_ok` = 1, is stored in full with status bits 20 and 19 set.
- R10: A frame longer than `MAX_FRAME` bytes, received with `long_ok` = 0, is dropped. No buffer word past the first `MAX_FRAME` bytes is written, the descriptor stays engine-owned and `irq_set` bits 3 and 0 pulse. A frame of exactly `MAX_FRAME` bytes is not too long.
- R11: A descriptor that is not engine-owned pulses `irq_set` bits 10 and 0. Frames are then discarded until `start_demand`, which refetches the same descriptor.
- R12: A memory request keeps its address, direction and data stable until `mem_ack`, and `s_ready` is never high while a request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_on | input | 1 | Receive enable |
| accept_unicast | input | 1 | Accept-all-unicast filter enable |
| long_ok | input | 1 | Store frames longer than MAX_FRAME |
| rx_irq_en | input | 1 | Set status bit 16 in written-back descriptors |
| list_base | input | AW | First descriptor address |
| start_demand | input | 1 | Resume pulse after a descriptor shortage |
| s_data | input | 8 | Stream byte |
| s_valid | input | 1 | Stream byte valid |
| s_last | input | 1 | Last byte of frame |
| s_ready | output | 1 | Stream byte accepted |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address, word aligned |
| mem_be | output | 4 | Write byte enables |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request completed |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| irq_set | output | IRQ_W | One-cycle interrupt-status set strobes |
| cur_desc | output | AW | Current descriptor pointer |

## Verification
The bench builds the engine with `MAX_FRAME` = 40, so both too-long paths (stored and dropped) and the exact-limit boundary are exercised with frames of 40, 44 and 48 bytes rather than more than 1500. A memory model with a one-cycle acknowledge delay drives a chain of three descriptors that wraps back onto a consumed one. This covers the shortage stall, the resume pulse and the partial-final-word byte enables.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
    typedef enum logic [2:0] {
        ST_OFF,
        ST_RD_STAT,
        ST_RD_BUF,
        ST_RD_NEXT,
        ST_RECV,
        ST_WR_DATA,
        ST_WR_STAT,
        ST_STALL
    } rxd_state_t;

    // interrupt-status bit positions decoded by the register file
    localparam int IRQ_RXINT  = 0;
    localparam int IRQ_LONG   = 3;
    localparam int IRQ_GOOD   = 4;
    localparam int IRQ_EARLY  = 9;
    localparam int IRQ_NODESC = 10;

    // written-back status word fields
    localparam int STW_GOOD = 20;
    localparam int STW_LONG = 19;
    localparam int STW_INT  = 16;

    localparam logic [1:0] OWN_ENGINE = 2'b10;
    localparam logic [1:0] OWN_CPU    = 2'b00;

    localparam int OFF_BUF  = 4;
    localparam int OFF_NEXT = 12;
    localparam int WORD_BYTES = 4;
endpackage

// File: rtl/rxd_packer.sv
module rxd_packer #(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic [7:0]       din,
    input  logic             last,
    input  logic             clr_pend,
    input  logic             new_frame,
    output logic             pend,
    output logic             eof,
    output logic [31:0]      word,
    output logic [3:0]       be,
    output logic [LEN_W-1:0] flen
);
    localparam int LANES = 4;
    localparam logic [LEN_W-1:0] LEN_MAX = {LEN_W{1'b1}};

    logic [1:0] lane;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word[8*g +: 8] <= '0;
                be[g]          <= 1'b0;
            end else if (clr_pend) begin
                be[g] <= 1'b0;
            end else if (take && lane == 2'(g)) begin
                word[8*g +: 8] <= din;
                be[g]          <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lane <= '0;
            pend <= 1'b0;
            eof  <= 1'b0;
            flen <= '0;
        end else begin
            if (new_frame) begin
                lane <= '0;
                eof  <= 1'b0;
                flen <= '0;
            end
            if (clr_pend) begin
                pend <= 1'b0;
            end
            if (take) begin
                lane <= last ? 2'd0 : lane + 2'd1;
                if (flen != LEN_MAX) begin
                    flen <= flen + 1'b1;
                end
                if (lane == 2'd3 || last) begin
                    pend <= 1'b1;
                    eof  <= last;
                end
            end
        end
    end
endmodule

// File: rtl/rxd_stat_word.sv
module rxd_stat_word #(
    parameter int LEN_W = 16
) (
    input  logic             good,
    input  logic             too_long,
    input  logic             intr,
    input  logic [LEN_W-1:0] len,
    output logic [31:0]      w
);
    import rxd_pkg::*;

    always_comb begin
        w           = '0;
        w[15:0]     = 16'(len);
        w[STW_GOOD] = good;
        w[STW_LONG] = too_long;
        w[STW_INT]  = intr;
        w[31:30]    = OWN_CPU;
    end
endmodule

// File: rtl/rxdesc_dma.sv
module rxdesc_dma
    import rxd_pkg::*;
#(
    parameter int AW        = 32,
    parameter int LEN_W     = 16,
    parameter int MAX_FRAME = 1518,
    parameter int IRQ_W     = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_on,
    input  logic             accept_unicast,
    input  logic             long_ok,
    input  logic             rx_irq_en,
    input  logic [AW-1:0]    list_base,
    input  logic             start_demand,
    input  logic [7:0]       s_data,
    input  logic             s_valid,
    input  logic             s_last,
    output logic             s_ready,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [3:0]       mem_be,
    output logic [31:0]      mem_wdata,
    input  logic             mem_ack,
    input  logic [31:0]      mem_rdata,
    output logic [IRQ_W-1:0] irq_set,
    output logic [AW-1:0]    cur_desc
);
    localparam logic [AW-1:0] STEP     = AW'(WORD_BYTES);
    localparam logic [AW-1:0] BUF_OFS  = AW'(OFF_BUF);
    localparam logic [AW-1:0] NEXT_OFS = AW'(OFF_NEXT);

    rxd_state_t state_q, state_d;

    logic [AW-1:0]    ptr_q, buf_q, nxt_q, wptr_q;
    logic             enabled, owned, too_long, drop_now;
    logic             take, clr_pend, new_frame;
    logic             pend, eof;
    logic [31:0]      word;
    logic [3:0]       be;
    logic [LEN_W-1:0] flen;
    logic [31:0]      stat_w;

    assign enabled  = rx_on && accept_unicast;
    assign owned    = (mem_rdata[31:30] == OWN_ENGINE);
    assign too_long = (32'(flen) > MAX_FRAME);
    assign drop_now = too_long && !long_ok;

    rxd_packer #(.LEN_W(LEN_W)) i_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (take),
        .din       (s_data),
        .last      (s_last),
        .clr_pend  (clr_pend),
        .new_frame (new_frame),
        .pend      (pend),
        .eof       (eof),
        .word      (word),
        .be        (be),
        .flen      (flen)
    );

    rxd_stat_word #(.LEN_W(LEN_W)) i_stat (
        .good     (1'b1),
        .too_long (too_long),
        .intr     (rx_irq_en),
        .len      (flen),
        .w        (stat_w)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:     if (enabled) state_d = ST_RD_STAT;
            ST_RD_STAT: if (mem_ack) state_d = owned ? ST_RD_BUF : ST_STALL;
            ST_RD_BUF:  if (mem_ack) state_d = ST_RD_NEXT;
            ST_RD_NEXT: if (mem_ack) state_d = ST_RECV;
            ST_RECV: begin
                if (!enabled && !pend && flen == '0) begin
                    state_d = ST_OFF;
                end else if (pend && !drop_now) begin
                    state_d = ST_WR_DATA;
                end
            end
            ST_WR_DATA: if (mem_ack) state_d = eof ? ST_WR_STAT : ST_RECV;
            ST_WR_STAT: if (mem_ack) state_d = ST_RD_STAT;
            ST_STALL: begin
                if (!enabled) begin
                    state_d = ST_OFF;
                end else if (start_demand) begin
                    state_d = ST_RD_STAT;
                end
            end
        endcase
    end

    // outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = ptr_q;
        mem_be    = 4'hF;
        mem_wdata = '0;
        s_ready   = 1'b0;
        irq_set   = '0;
        clr_pend  = 1'b0;
        new_frame = 1'b0;
        unique case (state_q)
            ST_OFF:   s_ready = 1'b1;
            ST_STALL: s_ready = 1'b1;
            ST_RD_STAT: begin
                mem_req = 1'b1;
                if (mem_ack && !owned) begin
                    irq_set[IRQ_NODESC] = 1'b1;
                    irq_set[IRQ_RXINT]  = 1'b1;
                end
            end
            ST_RD_BUF: begin
                mem_req  = 1'b1;
                mem_addr = ptr_q + BUF_OFS;
            end
            ST_RD_NEXT: begin
                mem_req   = 1'b1;
                mem_addr  = ptr_q + NEXT_OFS;
                new_frame = mem_ack;
            end
            ST_RECV: begin
                s_ready = !pend;
                if (pend && drop_now) begin
                    clr_pend = 1'b1;
                    if (eof) begin
                        new_frame          = 1'b1;
                        irq_set[IRQ_LONG]  = 1'b1;
                        irq_set[IRQ_RXINT] = 1'b1;
                    end
                end
            end
            ST_WR_DATA: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = wptr_q;
                mem_be    = be;
                mem_wdata = word;
                clr_pend  = mem_ack;
            end
            ST_WR_STAT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = stat_w;
                new_frame = mem_ack;
                if (mem_ack) begin
                    irq_set[IRQ_GOOD]  = 1'b1;
                    irq_set[IRQ_EARLY] = 1'b1;
                    irq_set[IRQ_RXINT] = 1'b1;
                end
            end
        endcase
    end

    assign take = s_valid && s_ready && (state_q == ST_RECV);

    // descriptor and buffer pointers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            buf_q  <= '0;
            nxt_q  <= '0;
            wptr_q <= '0;
        end else begin
            unique case (state_q)
                ST_OFF:    ptr_q <= list_base;
                ST_RD_BUF: if (mem_ack) buf_q <= mem_rdata[AW-1:0];
                ST_RD_NEXT: begin
                    if (mem_ack) begin
                        nxt_q  <= mem_rdata[AW-1:0];
                        wptr_q <= buf_q;
                    end
                end
                ST_RECV:    if (pend && drop_now && eof) wptr_q <= buf_q;
                ST_WR_DATA: if (mem_ack) wptr_q <= wptr_q + STEP;
                ST_WR_STAT: if (mem_ack) ptr_q <= nxt_q;
                default: ;
            endcase
        end
    end

    assign cur_desc = ptr_q;
endmodule

// File: rtl/rxdesc_dma_chk.sv
module rxdesc_dma_chk #(
    parameter int AW    = 32,
    parameter int IRQ_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             s_ready,
    input logic             mem_req,
    input logic             mem_we,
    input logic [AW-1:0]    mem_addr,
    input logic [31:0]      mem_wdata,
    input logic             mem_ack,
    input logic [IRQ_W-1:0] irq_set,
    input logic [AW-1:0]    cur_desc
);
    assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_wdata)));

    assert_ready_no_req_R12: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |-> !mem_req);

    assert_owner_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_addr == cur_desc) |-> (mem_wdata[31:30] == 2'b00));

    assert_good_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_set[4] |-> (irq_set[9] && irq_set[0] && !irq_set[3]));

    assert_nodesc_alone_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_set[10] |-> (irq_set[0] && !irq_set[4] && !irq_set[3]));

    assert_long_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_set[3] |-> (irq_set[0] && !irq_set[9]));
endmodule

bind rxdesc_dma rxdesc_dma_chk #(.AW(AW), .IRQ_W(IRQ_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .s_ready   (s_ready),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack),
    .irq_set   (irq_set),
    .cur_desc  (cur_desc)
);

// File: tb/test_rxdesc_dma.sv
`timescale 1ns/1ps
module test_rxdesc_dma;
    localparam int AW   = 32;
    localparam int MAXF = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic          rx_on = 0, accept_unicast = 0, long_ok = 0, rx_irq_en = 0;
    logic [AW-1:0] list_base = 32'h100;
    logic          start_demand = 0;
    logic [7:0]    s_data = 0;
    logic          s_valid = 0, s_last = 0;
    logic          s_ready, mem_req, mem_we, mem_ack;
    logic [AW-1:0] mem_addr, cur_desc;
    logic [3:0]    mem_be;
    logic [31:0]   mem_wdata, mem_rdata;
    logic [15:0]   irq_set;

    rxdesc_dma #(.AW(AW), .MAX_FRAME(MAXF)) i_rxdesc_dma (
        .clk(clk), .rst_n(rst_n), .rx_on(rx_on), .accept_unicast(accept_unicast),
        .long_ok(long_ok), .rx_irq_en(rx_irq_en), .list_base(list_base),
        .start_demand(start_demand), .s_data(s_data), .s_valid(s_valid),
        .s_last(s_last), .s_ready(s_ready), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .irq_set(irq_set),
        .cur_desc(cur_desc)
    );

    // memory model: acknowledge one cycle after a request
    logic [31:0] mem [0:1023];
    logic        bwr_en = 0;
    logic [31:0] bwr_addr = 0, bwr_data = 0;
    int          mem_writes = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
            mem_rdata <= '0;
        end else begin
            mem_ack <= mem_req && !mem_ack;
            if (mem_req && !mem_ack) begin
                if (mem_we) begin
                    mem_writes <= mem_writes + 1;
                    for (int b = 0; b < 4; b++)
                        if (mem_be[b]) mem[mem_addr[11:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
                end else begin
                    mem_rdata <= mem[mem_addr[11:2]];
                end
            end
        end
        if (bwr_en) mem[bwr_addr[11:2]] <= bwr_data;
    end

    int checks = 0, failures = 0;
    int mon_checks = 0, mon_fail = 0;
    logic [15:0] exp_irq[$];

    // every-clock comparison of status strobes against the expected event list
    always @(negedge clk) begin
        if (rst_n && irq_set != 16'h0) begin
            mon_checks++;
            if (exp_irq.size() == 0) begin
                mon_fail++;
                $display("FAIL R7/R10/R11 irq_set actual=%h expected=none", irq_set);
            end else begin
                logic [15:0] e;
                e = exp_irq.pop_front();
                if (irq_set !== e) begin
                    mon_fail++;
                    $display("FAIL R7/R10/R11 irq_set actual=%h expected=%h", irq_set, e);
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic poke(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        bwr_en = 1; bwr_addr = a; bwr_data = d;
        @(negedge clk);
        bwr_en = 0;
    endtask

    task automatic send_frame(input int n, input logic [7:0] base);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            s_valid = 1; s_data = base + 8'(i); s_last = (i == n - 1);
            while (!s_ready) @(negedge clk);
            @(posedge clk);
        end
        @(negedge clk);
        s_valid = 0; s_last = 0;
    endtask

    task automatic check_buf(input logic [31:0] a, input int n, input int words,
                             input logic [7:0] base, input string tag);
        for (int w = 0; w < words; w++) begin
            logic [31:0] e;
            for (int b = 0; b < 4; b++) begin
                int i;
                i = 4 * w + b;
                e[8*b +: 8] = (i < n) ? base + 8'(i) : 8'hEE;
            end
            chk(tag, mem[a[11:2] + 10'(w)], e);
        end
    endtask

    initial begin
        int wr0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 mem_req", {31'b0, mem_req}, 32'h0);
        chk("R1 irq_set", {16'b0, irq_set}, 32'h0);
        chk("R1 s_ready", {31'b0, s_ready}, 32'h1);
        chk("R1 cur_desc", cur_desc, 32'h100);

        for (int a = 32'h200; a < 32'h500; a += 4) poke(a, 32'hEEEE_EEEE);
        poke(32'h100, 32'h8000_0000); poke(32'h104, 32'h200); poke(32'h10C, 32'h110);
        poke(32'h110, 32'h8000_0000); poke(32'h114, 32'h300); poke(32'h11C, 32'h120);
        poke(32'h120, 32'h0000_0000); poke(32'h124, 32'h400); poke(32'h12C, 32'h100);

        // R2: enabled receive but unicast filter closed
        rx_on = 1;
        wr0 = mem_writes;
        send_frame(8, 8'h50);
        repeat (20) @(negedge clk);
        chk("R2 no memory write", 32'(mem_writes - wr0), 32'h0);
        chk("R2 desc0 untouched", mem[32'h100 >> 2], 32'h8000_0000);
        chk("R2 cur_desc", cur_desc, 32'h100);

        // R3 R4 R5 R6 R7 R8: 13-byte frame, interrupt disabled
        exp_irq.push_back(16'h0211);
        accept_unicast = 1;
        repeat (12) @(negedge clk);
        send_frame(13, 8'h10);
        repeat (30) @(negedge clk);
        chk("R5 R6 desc0 status", mem[32'h100 >> 2], 32'h0010_000D);
        check_buf(32'h200, 13, 4, 8'h10, "R4 buffer0");
        chk("R8 cur_desc after frame", cur_desc, 32'h110);

        // R9 R6: 44-byte frame, long allowed, interrupt enabled; then R11 shortage
        exp_irq.push_back(16'h0211);
        exp_irq.push_back(16'h0401);
        long_ok = 1; rx_irq_en = 1;
        send_frame(44, 8'h80);
        repeat (40) @(negedge clk);
        chk("R9 R6 desc1 status", mem[32'h110 >> 2], 32'h0019_002C);
        check_buf(32'h300, 44, 11, 8'h80, "R9 buffer1");
        chk("R8 cur_desc to desc2", cur_desc, 32'h120);

        // R11: frame discarded during shortage
        wr0 = mem_writes;
        send_frame(8, 8'hC0);
        repeat (20) @(negedge clk);
        chk("R11 no write while stalled", 32'(mem_writes - wr0), 32'h0);
        chk("R11 cur_desc held", cur_desc, 32'h120);

        // R11 resume; R10 drop of a 48-byte frame
        poke(32'h120, 32'h8000_0000);
        exp_irq.push_back(16'h0009);
        @(negedge clk); start_demand = 1;
        @(negedge clk); start_demand = 0;
        long_ok = 0;
        repeat (12) @(negedge clk);
        send_frame(48, 8'h20);
        repeat (20) @(negedge clk);
        chk("R10 desc2 still engine-owned", mem[32'h120 >> 2], 32'h8000_0000);
        chk("R10 cur_desc held", cur_desc, 32'h120);
        chk("R10 no write past limit", mem[(32'h400 >> 2) + 10], 32'hEEEE_EEEE);

        // R10 boundary: exactly MAXF bytes is a good frame; then desc0 is CPU-owned (R11)
        exp_irq.push_back(16'h0211);
        exp_irq.push_back(16'h0401);
        send_frame(40, 8'hA0);
        repeat (40) @(negedge clk);
        chk("R10 boundary desc2 status", mem[32'h120 >> 2], 32'h0011_0028);
        check_buf(32'h400, 40, 11, 8'hA0, "R4 buffer2");
        chk("R8 cur_desc wraps", cur_desc, 32'h100);

        repeat (10) @(negedge clk);
        chk("R7 R11 expected strobes all seen", 32'(exp_irq.size()), 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks + mon_checks, failures + mon_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        $display("FAIL watchdog R1-run actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks + mon_checks + 1,
                 failures + mon_fail + 1);
        $finish;
    end
endmodule